// File: doc/BRIEF.md
# Board Control Register File

A memory-mapped peripheral that gathers the small control functions of a board behind a plain 32-bit read/write bus: fixed readbacks for configuration switches, jumpers and board status, an 8-bit LED bar, an 8-character ASCII display buffer, a software reset trigger, two scratch-style byte registers (break/reset and general-purpose out) and a bit-banged two-wire register group that drives clock and data lines toward a serial EEPROM and reads the data line back.

Software reaches each register at a fixed offset within a decoded window. The display buffer can be loaded one character at a time, or as a whole: a single word write is turned into eight uppercase hexadecimal characters, so a 32-bit value can be shown directly. The software reset fires only when one key value is written, and then as a single-cycle pulse.

The bus is single-beat and has no wait states: a write takes effect on the clock edge where `bus_valid_i` and `bus_write_i` are both high, and read data is combinational while `bus_valid_i` is high and `bus_write_i` is low, zero otherwise.

Top module: `board_ctrl_regs`

## Requirements
- R1: Only address bits [19:0] are decoded (upper bits are ignored); a read of any offset not listed here returns 0 and a write to it changes no state or output.
- R2: Offsets 0x00200 (switches) and 0x00210 (jumpers) read 0 and ignore writes; offset 0x00208 (status) reads 0x12 when parameter BIG_ENDIAN is 1 and 0x10 when it is 0.
- R3: A write to 0x00408 stores data bits [7:0] as the LED bar; `leds_o` shows it from the cycle after the write edge and a read returns it zero-extended.
- R4: A write to 0x00410 sets display character k (bits [8k+7:8k] of `disp_o`, k = 0..7) to the uppercase ASCII hex digit of data nibble [31-4k:28-4k], so character 0 holds the most significant nibble ('0'..'9' = 0x30..0x39, 'A'..'F' = 0x41..0x46).
- R5: A write to offset 0x00418 + 8*k (k = 0..7) stores data bits [7:0] as display character k, leaving the other characters unchanged.
- R6: A write of exactly 0x00000042 to 0x00500 raises `sys_rst_req_o` for exactly one cycle, the cycle after the write edge; any other value there leaves it low.
- R7: Offsets 0x00508 (break/reset) and 0x00A00 (GP out) keep data bits [7:0]; 0x00B08 (two-wire output enable) keeps bits [1:0]; 0x00B18 (select) keeps bit 0; each reads back zero-extended.
- R8: A write to 0x00B10 stores all 32 data bits, which read back there; `scl_o` follows stored bit 1 and `sda_o` stored bit 0.
- R9: A read of 0x00B00 returns the stored input value 0x3 with bit 0 replaced by `sda_i` (0x2 or 0x3); a read of 0x00A08 returns the 0x00B10 value when select is 1 and 0 when select is 0.
- R10: After reset: LED bar 0x00, break/reset 0x0A, GP out 0x00, output enable 0x0, two-wire out 0x3, select 0x1, every display character 0x20 (space), `sys_rst_req_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus access in this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 32 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| leds_o | output | 8 | LED bar |
| disp_o | output | 64 | Display characters, character k in bits [8k+7:8k] |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| scl_o | output | 1 | Two-wire clock toward EEPROM |
| sda_o | output | 1 | Two-wire data toward EEPROM |
| sda_i | input | 1 | Two-wire data read back from EEPROM |

## Verification
The bench builds the block with BIG_ENDIAN set to 1 and the default 20-bit decode width, so the 0x12 status value is the one checked and addresses with nonzero bits above bit 19 alias onto the register window, letting the aliasing rule be exercised with ordinary offsets. A behavioural model of the register state follows every bus cycle and is compared against the LED, display, reset-request and two-wire outputs each clock, while reads are compared against values the model derives from the requirements, including hex expansion through a character lookup and the select-dependent GP-in value.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int unsigned NUM_CHARS = 8;
  localparam int unsigned CHAR_W    = 8;

  localparam logic [19:0] OFF_SWITCH = 20'h00200;
  localparam logic [19:0] OFF_STATUS = 20'h00208;
  localparam logic [19:0] OFF_JUMPER = 20'h00210;
  localparam logic [19:0] OFF_LED    = 20'h00408;
  localparam logic [19:0] OFF_WORD   = 20'h00410;
  localparam logic [19:0] OFF_POS0   = 20'h00418;
  localparam logic [19:0] POS_STEP   = 20'h00008;
  localparam logic [19:0] OFF_SRST   = 20'h00500;
  localparam logic [19:0] OFF_BRK    = 20'h00508;
  localparam logic [19:0] OFF_GPOUT  = 20'h00A00;
  localparam logic [19:0] OFF_GPIN   = 20'h00A08;
  localparam logic [19:0] OFF_TWIIN  = 20'h00B00;
  localparam logic [19:0] OFF_TWIOE  = 20'h00B08;
  localparam logic [19:0] OFF_TWIOUT = 20'h00B10;
  localparam logic [19:0] OFF_TWISEL = 20'h00B18;

  localparam logic [7:0]  BRK_RST    = 8'h0A;
  localparam logic [31:0] TWI_IN_RST = 32'h3;
  localparam logic [31:0] TWI_OUT_RST= 32'h3;
  localparam logic [7:0]  BLANK_CHAR = 8'h20;

  function automatic logic [7:0] hex_ascii(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction
endpackage

// File: rtl/bcr_disp.sv
module bcr_disp
  import bcr_pkg::*;
#(
  parameter int unsigned N = NUM_CHARS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_we_i,
  input  logic [N-1:0]      pos_we_i,
  input  logic [4*N-1:0]    word_i,
  input  logic [7:0]        char_i,
  output logic [8*N-1:0]    disp_o
);
  for (genvar k = 0; k < N; k++) begin : g_char
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           disp_o[8*k +: 8] <= BLANK_CHAR;
      else if (word_we_i)    disp_o[8*k +: 8] <= hex_ascii(word_i[4*(N-1-k) +: 4]);
      else if (pos_we_i[k])  disp_o[8*k +: 8] <= char_i;
    end
  end

  a_r5_disp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(word_we_i || (|pos_we_i)) |-> $stable(disp_o));
  a_r4_hex_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(word_we_i) |-> ((disp_o[7:0] >= 8'h30 && disp_o[7:0] <= 8'h39) ||
                          (disp_o[7:0] >= 8'h41 && disp_o[7:0] <= 8'h46)));
endmodule

// File: rtl/bcr_misc.sv
module bcr_misc
  import bcr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       led_we_i,
  input  logic       brk_we_i,
  input  logic       gp_we_i,
  input  logic       key_hit_i,
  input  logic [7:0] byte_i,
  output logic [7:0] leds_o,
  output logic [7:0] brk_o,
  output logic [7:0] gpout_o,
  output logic       rst_req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      leds_o    <= '0;
      brk_o     <= BRK_RST;
      gpout_o   <= '0;
      rst_req_o <= 1'b0;
    end else begin
      if (led_we_i) leds_o  <= byte_i;
      if (brk_we_i) brk_o   <= byte_i;
      if (gp_we_i)  gpout_o <= byte_i;
      rst_req_o <= key_hit_i;
    end
  end

  a_r6_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  a_r6_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(key_hit_i));
  a_r3_leds_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(led_we_i) |-> $stable(leds_o));
endmodule

// File: rtl/bcr_twi.sv
module bcr_twi
  import bcr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        oe_we_i,
  input  logic        out_we_i,
  input  logic        sel_we_i,
  input  logic [31:0] wdata_i,
  input  logic        sda_i,
  output logic [1:0]  oe_o,
  output logic [31:0] out_o,
  output logic        sel_o,
  output logic [31:0] in_o,
  output logic        scl_o,
  output logic        sda_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_o  <= '0;
      out_o <= TWI_OUT_RST;
      sel_o <= 1'b1;
    end else begin
      if (oe_we_i)  oe_o  <= wdata_i[1:0];
      if (out_we_i) out_o <= wdata_i;
      if (sel_we_i) sel_o <= wdata_i[0];
    end
  end

  assign scl_o = out_o[1];
  assign sda_o = out_o[0];
  assign in_o  = {TWI_IN_RST[31:1], sda_i};

  a_r8_lines_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(out_we_i) |-> ($stable(scl_o) && $stable(sda_o)));
  a_r8_lines_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(out_we_i) |-> (scl_o == $past(wdata_i[1]) && sda_o == $past(wdata_i[0])));
endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
  import bcr_pkg::*;
#(
  parameter bit          BIG_ENDIAN = 1'b0,
  parameter int unsigned DEC_W      = 20,
  parameter logic [31:0] SRST_KEY   = 32'h0000_0042
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    bus_valid_i,
  input  logic                    bus_write_i,
  input  logic [31:0]             bus_addr_i,
  input  logic [31:0]             bus_wdata_i,
  output logic [31:0]             bus_rdata_o,
  output logic [7:0]              leds_o,
  output logic [8*NUM_CHARS-1:0]  disp_o,
  output logic                    sys_rst_req_o,
  output logic                    scl_o,
  output logic                    sda_o,
  input  logic                    sda_i
);
  localparam logic [31:0] STATUS_VAL = BIG_ENDIAN ? 32'h12 : 32'h10;

  logic [19:0] off;
  logic        we, re;
  logic [31:0] unused_addr;
  assign off         = 20'(bus_addr_i[DEC_W-1:0]);
  assign unused_addr = bus_addr_i;
  assign we = bus_valid_i &&  bus_write_i;
  assign re = bus_valid_i && !bus_write_i;

  logic [NUM_CHARS-1:0] pos_we;
  for (genvar k = 0; k < NUM_CHARS; k++) begin : g_pos
    assign pos_we[k] = we && (off == OFF_POS0 + POS_STEP * 20'(k));
  end

  logic [7:0]  leds, brk, gpout;
  logic [1:0]  twi_oe;
  logic [31:0] twi_out, twi_in;
  logic        twi_sel;

  bcr_disp #(.N(NUM_CHARS)) i_disp (
    .clk_i, .rst_ni,
    .word_we_i (we && off == OFF_WORD),
    .pos_we_i  (pos_we),
    .word_i    (bus_wdata_i),
    .char_i    (bus_wdata_i[7:0]),
    .disp_o
  );

  bcr_misc i_misc (
    .clk_i, .rst_ni,
    .led_we_i  (we && off == OFF_LED),
    .brk_we_i  (we && off == OFF_BRK),
    .gp_we_i   (we && off == OFF_GPOUT),
    .key_hit_i (we && off == OFF_SRST && bus_wdata_i == SRST_KEY),
    .byte_i    (bus_wdata_i[7:0]),
    .leds_o    (leds),
    .brk_o     (brk),
    .gpout_o   (gpout),
    .rst_req_o (sys_rst_req_o)
  );

  bcr_twi i_twi (
    .clk_i, .rst_ni,
    .oe_we_i  (we && off == OFF_TWIOE),
    .out_we_i (we && off == OFF_TWIOUT),
    .sel_we_i (we && off == OFF_TWISEL),
    .wdata_i  (bus_wdata_i),
    .sda_i,
    .oe_o     (twi_oe),
    .out_o    (twi_out),
    .sel_o    (twi_sel),
    .in_o     (twi_in),
    .scl_o,
    .sda_o
  );

  assign leds_o = leds;

  always_comb begin
    bus_rdata_o = '0;
    if (re) begin
      case (off)
        OFF_STATUS: bus_rdata_o = STATUS_VAL;
        OFF_LED:    bus_rdata_o = {24'h0, leds};
        OFF_BRK:    bus_rdata_o = {24'h0, brk};
        OFF_GPOUT:  bus_rdata_o = {24'h0, gpout};
        OFF_GPIN:   bus_rdata_o = twi_sel ? twi_out : 32'h0;
        OFF_TWIIN:  bus_rdata_o = twi_in;
        OFF_TWIOE:  bus_rdata_o = {30'h0, twi_oe};
        OFF_TWIOUT: bus_rdata_o = twi_out;
        OFF_TWISEL: bus_rdata_o = {31'h0, twi_sel};
        default:    bus_rdata_o = '0;
      endcase
    end
  end

  a_r1_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re |-> bus_rdata_o == 32'h0);
  a_r9_twiin_sda: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re && off == OFF_TWIIN) |-> bus_rdata_o[0] == sda_i);
endmodule

// File: tb/test_board_ctrl_regs.sv
module test_board_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  leds;
  logic [63:0] disp;
  logic        rst_req, scl, sda, sda_in = 1'b1;

  always #4 clk = ~clk;

  board_ctrl_regs #(.BIG_ENDIAN(1'b1), .DEC_W(20)) i_board_ctrl_regs (
    .clk_i(clk), .rst_ni(rst_ni),
    .bus_valid_i(bus_valid), .bus_write_i(bus_write),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .leds_o(leds), .disp_o(disp), .sys_rst_req_o(rst_req),
    .scl_o(scl), .sda_o(sda), .sda_i(sda_in)
  );

  int vectors = 0, miscompares = 0;
  bit done = 0;
  string hexs = "0123456789ABCDEF";

  // reference model
  int m_leds, m_brk, m_gp, m_oe, m_sel;
  logic [31:0] m_out;
  byte m_chr[8];
  bit  m_rst;

  task automatic model_reset();
    m_leds = 0; m_brk = 'h0A; m_gp = 0; m_oe = 0; m_out = 32'h3; m_sel = 1; m_rst = 0;
    foreach (m_chr[i]) m_chr[i] = 8'h20;
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) model_reset();
    else begin
      int o;
      o = int'(bus_addr & 32'hFFFFF);
      m_rst = 0;
      if (bus_valid && bus_write) begin
        if (o == 'h408) m_leds = int'(bus_wdata & 32'hFF);
        if (o == 'h508) m_brk  = int'(bus_wdata & 32'hFF);
        if (o == 'hA00) m_gp   = int'(bus_wdata & 32'hFF);
        if (o == 'hB08) m_oe   = int'(bus_wdata & 32'h3);
        if (o == 'hB18) m_sel  = int'(bus_wdata & 32'h1);
        if (o == 'hB10) m_out  = bus_wdata;
        if (o == 'h500 && bus_wdata == 32'h42) m_rst = 1;
        if (o == 'h410)
          for (int i = 0; i < 8; i++) m_chr[i] = byte'(hexs[(bus_wdata >> (28 - 4*i)) & 'hF]);
        if (o >= 'h418 && o <= 'h450 && (o % 8) == 0) m_chr[(o - 'h418) / 8] = byte'(bus_wdata & 'hFF);
      end
    end
  end

  function automatic logic [31:0] exp_read(logic [31:0] a);
    int o;
    o = int'(a & 32'hFFFFF);
    case (o)
      'h208: return 32'h12;
      'h408: return m_leds;
      'h508: return m_brk;
      'hA00: return m_gp;
      'hA08: return m_sel ? m_out : 0;
      'hB00: return 32'h2 | {31'h0, sda_in};
      'hB08: return m_oe;
      'hB10: return m_out;
      'hB18: return m_sel;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-clock output comparison
  always @(negedge clk) if (rst_ni && !done) begin
    logic [63:0] pk;
    for (int i = 0; i < 8; i++) pk[8*i +: 8] = m_chr[i];
    chk("R3 leds", {56'h0, leds}, 64'(m_leds));
    chk("R4/R5 disp", disp, pk);
    chk("R6 rst_req", {63'h0, rst_req}, {63'h0, m_rst});
    chk("R8 scl/sda", {62'h0, scl, sda}, {62'h0, m_out[1], m_out[0]});
  end

  task automatic wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
  endtask

  task automatic rd(string tag, logic [31:0] a);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #2 chk(tag, {32'h0, bus_rdata}, {32'h0, exp_read(a)});
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    #2 chk("R1 idle rdata", {32'h0, bus_rdata}, 64'h0);
  endtask

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R10 reset values
    rd("R10 leds", 32'h408); rd("R10 brk", 32'h508); rd("R10 gp", 32'hA00);
    rd("R10 oe", 32'hB08); rd("R10 out", 32'hB10); rd("R10 sel", 32'hB18);
    rd("R2 status", 32'h208); rd("R2 switch", 32'h200); rd("R2 jumper", 32'h210);
    // R9 two-wire input and GP-in
    sda_in = 1; rd("R9 in sda1", 32'hB00);
    sda_in = 0; rd("R9 in sda0", 32'hB00);
    rd("R9 gpin sel1", 32'hA08);
    // R2 writes ignored
    wr(32'h200, 32'hFFFF_FFFF); wr(32'h210, 32'h1234_5678);
    rd("R2 switch after wr", 32'h200); rd("R2 jumper after wr", 32'h210);
    // R3 LED
    wr(32'h408, 32'h0000_1234); rd("R3 led rd", 32'h408);
    wr(32'h408, 32'hFFFF_FFA5); idle(); rd("R3 led rd2", 32'h408);
    // R1 aliasing and unmapped
    wr(32'hFFF0_0408, 32'h0000_005C); rd("R1 alias led", 32'h0010_0408);
    wr(32'h0000_0404, 32'h0000_00FF); wr(32'h0000_0419, 32'h0000_0041);
    wr(32'h0000_0B04, 32'hFFFF_FFFF);
    rd("R1 unmapped 404", 32'h404); rd("R1 unmapped 0", 32'h0); rd("R1 unmapped B20", 32'hB20);
    // R4 word expansion
    wr(32'h410, 32'hDEAD_BEEF); idle();
    wr(32'h410, 32'h0123_4567); idle();
    wr(32'h410, 32'h89AB_CDEF); idle();
    // R5 positions
    for (int k = 0; k < 8; k++) wr(32'h418 + 8*k, 32'hFFFF_FF00 | (32'h61 + k));
    idle();
    wr(32'h430, 32'h0000_002A); idle();
    // R6 soft reset
    wr(32'h500, 32'h0000_0043); idle();
    wr(32'h500, 32'h0000_0142); idle();
    wr(32'h500, 32'h0000_0042); idle(); idle();
    wr(32'h508, 32'h0000_0042); idle();
    // R7 byte/bit registers
    wr(32'h508, 32'hABCD_EF77); rd("R7 brk", 32'h508);
    wr(32'hA00, 32'h1234_56C3); rd("R7 gp", 32'hA00);
    wr(32'hB08, 32'hFFFF_FFFE); rd("R7 oe", 32'hB08);
    wr(32'hB18, 32'hFFFF_FFFE); rd("R7 sel0", 32'hB18);
    // R9 GP-in with select 0
    rd("R9 gpin sel0", 32'hA08);
    // R8 two-wire out
    wr(32'hB10, 32'hCAFE_0000); rd("R8 out", 32'hB10);
    wr(32'hB10, 32'h0000_0002); idle();
    wr(32'hB10, 32'h0000_0001); idle();
    wr(32'hB18, 32'h0000_0001); rd("R9 gpin sel1b", 32'hA08);
    wr(32'hB10, 32'h5555_5557); rd("R9 gpin follow", 32'hA08);
    sda_in = 1; rd("R9 in sda1b", 32'hB00);
    // R10 reset again mid-run
    @(negedge clk); bus_valid = 0; rst_ni = 0;
    @(negedge clk); rst_ni = 1;
    rd("R10 brk again", 32'h508); rd("R10 sel again", 32'h0B18);
    idle(); idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule